// File: doc/BRIEF.md
# Reference Clock Divider with Glitch-Free Reprogramming

This block derives a slower clock from a 48 MHz reference. It divides the reference by one plus a 4-bit divisor value that firmware writes into a single configuration byte. Firmware can rewrite the divisor while the output is toggling. The phase in progress is then stretched or cut to the new length, and no pulse shorter than the new phase appears on the output.

A disable bit in the same byte holds the output at the level it had when the freeze took hold. When firmware clears the bit, the output starts a fresh period with a full high phase. The byte is written through a write strobe with an 8-bit data bus. It is read back combinationally while a read strobe is asserted.

The core is a three-state phase machine. In `PH_HIGH` the output is driven high and a phase counter runs. `PH_HIGH` moves to `PH_LOW` when the high length is reached, and `PH_LOW` moves back to `PH_HIGH` when the low length is reached. Any state moves to `PH_HOLD` while the disable bit is set. `PH_HOLD` moves to `PH_HIGH` with a cleared counter once the bit is clear.

Top module: `refclk_divider`

## Requirements
- R1: After reset the divisor field holds 11, the disable bit holds 0, a read returns 0x0B, and `clk_out` is high.
- R2: The output period is (divisor + 1) reference cycles. At the reset value this is 6 cycles high and 6 cycles low.
- R3: For an odd ratio N = divisor + 1, the high phase lasts ceil(N/2) cycles and the low phase lasts floor(N/2) cycles. A divisor of 4 gives 3 cycles high and 2 cycles low.
- R4: A divisor of 0 behaves as divide-by-2, with 1 cycle high and 1 cycle low.
- R5: The divisor occupies bits 3:0 and the disable bit occupies bit 7. Bits 6:4 ignore writes and read as 0.
- R6: While `cfg_re` is high, `cfg_rdata` shows the register in the same cycle. Otherwise it reads 0. A write strobed at a clock edge is visible from that edge on.
- R7: Raising the divisor during a phase extends that phase to the new phase length.
- R8: Lowering the divisor during a phase below the elapsed count ends the phase one cycle after the new value is loaded. The following phases use the new lengths.
- R9: Setting the disable bit freezes `clk_out` at its current level, one cycle after the register takes the write.
- R10: Clearing the disable bit restarts the output with a complete high phase, followed by a complete low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Write data |
| cfg_re | input | 1 | Read strobe |
| cfg_rdata | output | 8 | Read data, valid in the cycle of `cfg_re` |
| clk_out | output | 1 | Divided clock output |

## Verification
The bench rewrites the divisor in the middle of a high phase, both upward and downward. A design that restarted the counter on a write would give a phase that is too long. A design that compared for equality instead of "reached or passed" would skip past a shortened limit and run for many cycles. The bench freezes the output in both the high and the low phase. A design that forced the output low on disable, or that resumed the old partial phase, would show a wrong level or a short first high phase. Odd ratios and divisor 0 catch rounding the wrong way and a counter that can never reach a zero-length phase.

// File: rtl/refclk_div_pkg.sv
package refclk_div_pkg;
    typedef enum logic [1:0] {
        PH_HIGH = 2'd0,
        PH_LOW  = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;
endpackage

// File: rtl/refclk_div_cfg.sv
module refclk_div_cfg #(
    parameter int DATA_W    = 8,
    parameter int DIV_W     = 4,
    parameter int DIS_BIT   = 7,
    parameter int RESET_DIV = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    output logic [DATA_W-1:0] rdata,
    output logic [DIV_W-1:0]  div_q,
    output logic              dis_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_W'(RESET_DIV);
            dis_q <= 1'b0;
        end else if (we) begin
            div_q <= wdata[DIV_W-1:0];
            dis_q <= wdata[DIS_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        if (re) begin
            rdata[DIV_W-1:0] = div_q;
            rdata[DIS_BIT]   = dis_q;
        end
    end
endmodule

// File: rtl/refclk_div_fsm.sv
module refclk_div_fsm
    import refclk_div_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             dis,
    output logic             clk_out
);
    localparam int LW = DIV_W + 2;

    phase_e          state_q, state_n;
    logic [LW-1:0]   cnt_q, cnt_n;
    logic [LW-1:0]   ratio, len_hi, len_lo, cnt_inc;
    logic            out_q;

    // Phase lengths follow the divisor currently held in the register.
    always_comb begin
        ratio   = (div == '0) ? LW'(2) : LW'(div) + LW'(1);
        len_hi  = (ratio + LW'(1)) >> 1;
        len_lo  = ratio >> 1;
        cnt_inc = cnt_q + LW'(1);
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (dis) begin
            state_n = PH_HOLD;
        end else begin
            unique case (state_q)
                PH_HIGH: begin
                    if (cnt_inc >= len_hi) begin
                        state_n = PH_LOW;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end
                PH_LOW: begin
                    if (cnt_inc >= len_lo) begin
                        state_n = PH_HIGH;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end
                PH_HOLD: begin
                    state_n = PH_HIGH;
                    cnt_n   = '0;
                end
                default: begin
                    state_n = PH_HIGH;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_HIGH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b1;
        end else begin
            out_q <= (state_n == PH_HIGH) || ((state_n == PH_HOLD) && out_q);
        end
    end

    assign clk_out = out_q;
endmodule

// File: rtl/refclk_divider.sv
module refclk_divider #(
    parameter int DATA_W    = 8,
    parameter int DIV_W     = 4,
    parameter int DIS_BIT   = 7,
    parameter int RESET_DIV = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              cfg_re,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              clk_out
);
    logic [DIV_W-1:0] div_q;
    logic             dis_q;

    refclk_div_cfg #(
        .DATA_W(DATA_W), .DIV_W(DIV_W), .DIS_BIT(DIS_BIT), .RESET_DIV(RESET_DIV)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .re(cfg_re), .rdata(cfg_rdata), .div_q(div_q), .dis_q(dis_q)
    );

    refclk_div_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .div(div_q), .dis(dis_q), .clk_out(clk_out)
    );
endmodule

// File: rtl/refclk_divider_chk.sv
module refclk_divider_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic       cfg_re,
    input logic [7:0] cfg_rdata,
    input logic       dis_q,
    input logic       clk_out
);
    // R9
    freeze_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dis_q) |-> $stable(clk_out));

    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[6:4] == 3'b000);

    // R6
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_re |-> cfg_rdata == 8'h00);

    // R6
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_we) && cfg_re) |->
            (cfg_rdata[3:0] == $past(cfg_wdata[3:0]) && cfg_rdata[7] == $past(cfg_wdata[7])));
endmodule

bind refclk_divider refclk_divider_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_re(cfg_re), .cfg_rdata(cfg_rdata), .dis_q(dis_q), .clk_out(clk_out)
);

// File: tb/refclk_divider_bench.sv
module refclk_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       cfg_re = 1'b0;
    logic [7:0] cfg_rdata;
    logic       clk_out;
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;

    always #10 clk = ~clk;

    refclk_divider u_refclk_divider (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_re(cfg_re), .cfg_rdata(cfg_rdata), .clk_out(clk_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sync_rise();
        do @(negedge clk); while (clk_out !== 1'b0);
        do @(negedge clk); while (clk_out !== 1'b1);
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (clk_out === lvl && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // High phase with a write issued after k counted high cycles.
    task automatic high_with_write(input int k, input logic [7:0] v, output int n);
        n = 0;
        while (clk_out === 1'b1 && n < 1000) begin
            n++;
            if (n == k) begin cfg_we = 1'b1; cfg_wdata = v; end
            else cfg_we = 1'b0;
            @(negedge clk);
        end
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        cfg_re = 1'b1; #1;
        chk("R1 read", int'(cfg_rdata), 8'h0B);
        chk("R1 clk_out", int'(clk_out), 1);
        cfg_re = 1'b0; #1;
        chk("R6 idle read", int'(cfg_rdata), 0);
    endtask

    task automatic t_ratio(input logic [7:0] v, input int hi, input int lo, input string req);
        int a, b;
        write_cfg(v);
        sync_rise();
        run_len(1'b1, a);
        run_len(1'b0, b);
        chk({req, " high"}, a, hi);
        chk({req, " low"}, b, lo);
    endtask

    task automatic t_reserved();
        write_cfg(8'h7F);
        cfg_re = 1'b1; #1;
        chk("R5 reserved", int'(cfg_rdata), 8'h0F);
        cfg_re = 1'b0;
    endtask

    task automatic t_lengthen();
        int a, b;
        write_cfg(8'h09);
        sync_rise();
        high_with_write(2, 8'h0F, a);
        run_len(1'b0, b);
        chk("R7 stretched high", a, 8);
        chk("R7 new low", b, 8);
    endtask

    task automatic t_shorten();
        int a, b, c;
        write_cfg(8'h0F);
        sync_rise();
        high_with_write(5, 8'h03, a);
        run_len(1'b0, b);
        run_len(1'b1, c);
        chk("R8 cut high", a, 6);
        chk("R8 new low", b, 2);
        chk("R8 new high", c, 2);
    endtask

    task automatic t_freeze_high();
        int a, stuck;
        write_cfg(8'h09);
        sync_rise();
        high_with_write(3, 8'h89, a);
        stuck = 1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (clk_out !== 1'b1) stuck = 0;
        end
        chk("R9 frozen high", stuck, 1);
    endtask

    task automatic t_freeze_low();
        int a, b, stuck;
        write_cfg(8'h09);
        sync_rise();
        run_len(1'b1, a);
        @(negedge clk);
        write_cfg(8'h89);
        stuck = 1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (clk_out !== 1'b0) stuck = 0;
        end
        chk("R9 frozen low", stuck, 1);
        write_cfg(8'h09);
        run_len(1'b0, b);
        chk("R10 resume quickly", int'(b <= 2), 1);
        run_len(1'b1, a);
        run_len(1'b0, b);
        chk("R10 fresh high", a, 5);
        chk("R10 fresh low", b, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        begin
            int a, b;
            sync_rise();
            run_len(1'b1, a);
            run_len(1'b0, b);
            chk("R2 default high", a, 6);
            chk("R2 default low", b, 6);
        end
        t_ratio(8'h04, 3, 2, "R3 div4");
        t_ratio(8'h06, 4, 3, "R3 div6");
        t_ratio(8'h00, 1, 1, "R4 div0");
        t_ratio(8'h01, 1, 1, "R4 div1");
        t_reserved();
        t_lengthen();
        t_shorten();
        t_freeze_high();
        t_freeze_low();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule